// File: doc/BRIEF.md
# Page Store Register Controller

This block puts a 512-page store, each page 128 bits wide, behind a small register bus. Software stages a page image in four 32-bit data words, chooses which of the sixteen bytes take part through a 16-bit byte-enable register, and then writes a control word. That control word names a page and asks for a page write (data words into the page), a page read (page into the data words), or both. The transfer finishes in the same clock edge that accepts the control write, and a sticky done flag in the status register records it. The store is an ordinary writable array. Every page can be read and written any number of times.

The bus carries a size code with each request, and every register accepts exactly one width. A request with an illegal size, a register hit with the wrong width, or an offset that maps to nothing is refused. A refused request pulses an error output for one cycle and returns zero read data, and it changes no state. Read data and the error flag are registered and appear one cycle after the request.

Top module: `otp_page_ctrl`

## Requirements
- R1: After reset, control reads 0x0000, byte-enable 0xFFFF, status 0x0000, timing 0x00001485, every data word 0, and the error output is low.
- R2: The size code is 0 for 8-bit, 1 for 16-bit, 2 for 32-bit and 3 for 64-bit. Codes 0 and 3 are refused at every offset, and that check comes before the address is decoded. Control, byte-enable and status accept code 1 only. Timing and the four data words accept code 2 only.
- R3: The mapped offsets are control 0x00, byte-enable 0x04, status 0x08, timing 0x0C and data words 0 to 3 at 0x80, 0x84, 0x88 and 0x8C. Any other offset is refused. A refused request returns read data 0.
- R4: A refused write changes no register and starts no page transfer.
- R5: A control write stores the written value ANDed with 0x39FF, and control reads back that stored value.
- R6: Control bit 11 requests a page write to the page in control bits 8:0. Page byte i takes data byte i only when byte-enable bit i is 1. Every other byte of the page keeps its old value.
- R7: Control bit 12 requests a page read from the page in bits 8:0. Data byte i takes page byte i only when byte-enable bit i is 1. Every other data byte keeps its old value.
- R8: Page byte i lives in data word i/4 at bit position 8*(i mod 4). Data word 0 therefore holds bytes 0 to 3, little-endian, and data word 3 holds bytes 12 to 15.
- R9: When bits 11 and 12 are both set, the page write happens first and the read follows. The page is updated, and the data words are left unchanged.
- R10: Every accepted control write sets status bit 0, and the flag is visible from the next cycle. A 16-bit status write clears each bit written as 1 and leaves each bit written as 0.
- R11: Byte-enable takes all 16 written bits. Timing and the data words take all 32 written bits.
- R12: Read data and the error pulse appear in the cycle after the request. The error output is high only in the cycle after a refused request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset from the block base |
| bus_size | input | 2 | Access size code (0=8, 1=16, 2=32, 3=64 bits) |
| bus_wdata | input | 32 | Write data; 16-bit registers use bits 15:0 |
| bus_rdata | output | 32 | Read data, registered; 16-bit registers zero-extended |
| bus_err | output | 1 | One-cycle pulse for a refused request |

## Verification
The bench sweeps every byte offset against every size code. Each read is compared with the expected error and data. A design that decoded the address before judging the size, or that let an aligned but unmapped offset through, would show a missing error or stray read data. Writes of every wrong width are aimed at each register and the registers are read back afterwards, which catches a refused write that still commits or that starts a page transfer. Page transfers run with byte-enable patterns 0xFFFF, 0x0000, 0x00FF, 0xA5C3 and 0x8001 on pages 0, 1, 0x0AA, 0x155 and 0x1FF. A swapped byte order, an inverted or ignored mask, or a write and read done in the wrong order shows up as wrong bytes in the words read back.

// File: rtl/otp_pkg.sv
package otp_pkg;

  localparam int WORD_W     = 32;
  localparam int PAGE_BYTES = 16;
  localparam int PAGE_W     = PAGE_BYTES * 8;
  localparam int WORDS      = PAGE_W / WORD_W;
  localparam int HALF_W     = 16;

  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_64 = 2'd3
  } bus_size_e;

  typedef enum logic [3:0] {
    REG_CTRL, REG_BEN, REG_STAT, REG_TIME,
    REG_D0, REG_D1, REG_D2, REG_D3, REG_NONE
  } reg_id_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_WIDTH = 2'd1,
    ERR_MAP   = 2'd2
  } err_kind_e;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_BEN  = 8'h04;
  localparam logic [7:0] OFS_STAT = 8'h08;
  localparam logic [7:0] OFS_TIME = 8'h0C;
  localparam logic [7:0] OFS_D0   = 8'h80;
  localparam logic [7:0] OFS_D1   = 8'h84;
  localparam logic [7:0] OFS_D2   = 8'h88;
  localparam logic [7:0] OFS_D3   = 8'h8C;

  localparam logic [15:0] CTRL_KEEP   = 16'h39FF;
  localparam int          CTRL_WR_BIT = 11;
  localparam int          CTRL_RD_BIT = 12;
  localparam int          DONE_BIT    = 0;
  localparam logic [15:0] BEN_INIT    = 16'hFFFF;
  localparam logic [31:0] TIME_INIT   = 32'h0000_1485;

  // Byte-masked merge: byte b of the result is src when en[b], else dst.
  function automatic logic [PAGE_W-1:0] merge_bytes(
    input logic [PAGE_W-1:0]     dst,
    input logic [PAGE_W-1:0]     src,
    input logic [PAGE_BYTES-1:0] en
  );
    logic [PAGE_W-1:0] res;
    res = dst;
    for (int b = 0; b < PAGE_BYTES; b++) begin
      if (en[b]) res[8*b +: 8] = src[8*b +: 8];
    end
    return res;
  endfunction

  // Size code that a given register accepts.
  function automatic bus_size_e width_for(input reg_id_e r);
    case (r)
      REG_CTRL, REG_BEN, REG_STAT: return SZ_16;
      default:                     return SZ_32;
    endcase
  endfunction

  // Only 16- and 32-bit sizes may reach address decode.
  function automatic logic size_legal(input logic [1:0] s);
    return (s == SZ_16) || (s == SZ_32);
  endfunction

endpackage

// File: rtl/otp_bus_decode.sv
module otp_bus_decode
  import otp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output reg_id_e           reg_id,
  output err_kind_e         err_kind,
  output logic              acc_ok,
  output logic              err_now
);

  localparam int OFS_W = 8;

  logic [ADDR_W-1:0] a_ctrl, a_ben, a_stat, a_time;
  logic [ADDR_W-1:0] a_d0, a_d1, a_d2, a_d3;

  assign a_ctrl = ADDR_W'(OFS_CTRL);
  assign a_ben  = ADDR_W'(OFS_BEN);
  assign a_stat = ADDR_W'(OFS_STAT);
  assign a_time = ADDR_W'(OFS_TIME);
  assign a_d0   = ADDR_W'(OFS_D0);
  assign a_d1   = ADDR_W'(OFS_D1);
  assign a_d2   = ADDR_W'(OFS_D2);
  assign a_d3   = ADDR_W'(OFS_D3);

  initial begin
    if (ADDR_W < OFS_W) $error("otp_bus_decode: ADDR_W too small for register map");
  end

  always_comb begin
    if      (req_addr == a_ctrl) reg_id = REG_CTRL;
    else if (req_addr == a_ben)  reg_id = REG_BEN;
    else if (req_addr == a_stat) reg_id = REG_STAT;
    else if (req_addr == a_time) reg_id = REG_TIME;
    else if (req_addr == a_d0)   reg_id = REG_D0;
    else if (req_addr == a_d1)   reg_id = REG_D1;
    else if (req_addr == a_d2)   reg_id = REG_D2;
    else if (req_addr == a_d3)   reg_id = REG_D3;
    else                         reg_id = REG_NONE;
  end

  // Size legality is judged before the map; a mapped register then
  // demands its own width.
  always_comb begin
    if (!size_legal(req_size))                    err_kind = ERR_WIDTH;
    else if (reg_id == REG_NONE)                  err_kind = ERR_MAP;
    else if (bus_size_e'(req_size) != width_for(reg_id)) err_kind = ERR_WIDTH;
    else                                          err_kind = ERR_NONE;
  end

  assign acc_ok  = req_valid && (err_kind == ERR_NONE);
  assign err_now = req_valid && (err_kind != ERR_NONE);

endmodule

// File: rtl/otp_page_store.sv
module otp_page_store
  import otp_pkg::*;
#(
  parameter int PAGES   = 512,
  parameter int PAGE_AW = $clog2(PAGES)
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [PAGE_AW-1:0]    page_sel,
  input  logic [PAGE_BYTES-1:0] wr_mask,
  input  logic [PAGE_W-1:0]     wr_page,
  output logic [PAGE_W-1:0]     rd_page
);

  logic [PAGE_W-1:0] cells [PAGES];

  assign rd_page = cells[page_sel];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < PAGE_BYTES; b++) begin
        if (wr_mask[b]) cells[page_sel][8*b +: 8] <= wr_page[8*b +: 8];
      end
    end
  end

endmodule

// File: rtl/otp_regfile.sv
module otp_regfile
  import otp_pkg::*;
#(
  parameter int PAGE_AW = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_ok,
  input  logic                  acc_write,
  input  reg_id_e               reg_id,
  input  logic [WORD_W-1:0]     wdata,
  input  logic [PAGE_W-1:0]     page_rd,
  output logic [HALF_W-1:0]     ctrl_q,
  output logic [HALF_W-1:0]     ben_q,
  output logic [HALF_W-1:0]     stat_q,
  output logic [WORD_W-1:0]     timing_q,
  output logic [PAGE_W-1:0]     data_vec,
  output logic                  ctrl_go,
  output logic                  wr_req,
  output logic                  rd_req,
  output logic [PAGE_AW-1:0]    pg_addr,
  output logic                  pg_we,
  output logic [PAGE_BYTES-1:0] pg_mask,
  output logic [PAGE_W-1:0]     pg_wdata,
  output logic [WORD_W-1:0]     rd_word
);

  logic              reg_we;
  logic [PAGE_W-1:0] page_after;
  logic [PAGE_W-1:0] data_loaded;
  logic [PAGE_W-1:0] data_next;
  logic [HALF_W-1:0] stat_next;

  assign reg_we  = acc_ok && acc_write;
  assign ctrl_go = reg_we && (reg_id == REG_CTRL);
  assign wr_req  = ctrl_go && wdata[CTRL_WR_BIT];
  assign rd_req  = ctrl_go && wdata[CTRL_RD_BIT];
  assign pg_addr = wdata[PAGE_AW-1:0];

  assign pg_we    = wr_req;
  assign pg_mask  = ben_q;
  assign pg_wdata = data_vec;

  // Write goes first: the read sees the page as the write leaves it.
  assign page_after  = wr_req ? merge_bytes(page_rd, data_vec, ben_q) : page_rd;
  assign data_loaded = merge_bytes(data_vec, page_after, ben_q);

  always_comb begin
    data_next = data_vec;
    if (rd_req) data_next = data_loaded;
    if (reg_we) begin
      case (reg_id)
        REG_D0:  data_next[0*WORD_W +: WORD_W] = wdata;
        REG_D1:  data_next[1*WORD_W +: WORD_W] = wdata;
        REG_D2:  data_next[2*WORD_W +: WORD_W] = wdata;
        REG_D3:  data_next[3*WORD_W +: WORD_W] = wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    stat_next = stat_q;
    if (reg_we && reg_id == REG_STAT) stat_next = stat_q & ~wdata[HALF_W-1:0];
    if (ctrl_go) stat_next[DONE_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      ben_q    <= BEN_INIT;
      stat_q   <= '0;
      timing_q <= TIME_INIT;
      data_vec <= '0;
    end else begin
      data_vec <= data_next;
      stat_q   <= stat_next;
      if (ctrl_go) ctrl_q <= wdata[HALF_W-1:0] & CTRL_KEEP;
      if (reg_we && reg_id == REG_BEN)  ben_q    <= wdata[HALF_W-1:0];
      if (reg_we && reg_id == REG_TIME) timing_q <= wdata;
    end
  end

  always_comb begin
    case (reg_id)
      REG_CTRL: rd_word = {16'h0, ctrl_q};
      REG_BEN:  rd_word = {16'h0, ben_q};
      REG_STAT: rd_word = {16'h0, stat_q};
      REG_TIME: rd_word = timing_q;
      REG_D0:   rd_word = data_vec[0*WORD_W +: WORD_W];
      REG_D1:   rd_word = data_vec[1*WORD_W +: WORD_W];
      REG_D2:   rd_word = data_vec[2*WORD_W +: WORD_W];
      REG_D3:   rd_word = data_vec[3*WORD_W +: WORD_W];
      default:  rd_word = '0;
    endcase
  end

endmodule

// File: rtl/otp_page_ctrl.sv
module otp_page_ctrl
  import otp_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int PAGES   = 512,
  parameter int PAGE_AW = $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err
);

  reg_id_e               reg_id;
  err_kind_e             err_kind;
  logic                  acc_ok;
  logic                  err_now;
  logic [HALF_W-1:0]     ctrl_q, ben_q, stat_q;
  logic [WORD_W-1:0]     timing_q;
  logic [PAGE_W-1:0]     data_vec;
  logic                  ctrl_go, wr_req, rd_req;
  logic [PAGE_AW-1:0]    pg_addr;
  logic                  pg_we;
  logic [PAGE_BYTES-1:0] pg_mask;
  logic [PAGE_W-1:0]     pg_wdata, pg_rdata;
  logic [WORD_W-1:0]     rd_word;
  logic [WORD_W-1:0]     rdata_q;
  logic                  err_q;

  otp_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid (bus_valid),
    .req_addr  (bus_addr),
    .req_size  (bus_size),
    .reg_id    (reg_id),
    .err_kind  (err_kind),
    .acc_ok    (acc_ok),
    .err_now   (err_now)
  );

  otp_regfile #(.PAGE_AW(PAGE_AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_ok    (acc_ok),
    .acc_write (bus_write),
    .reg_id    (reg_id),
    .wdata     (bus_wdata),
    .page_rd   (pg_rdata),
    .ctrl_q    (ctrl_q),
    .ben_q     (ben_q),
    .stat_q    (stat_q),
    .timing_q  (timing_q),
    .data_vec  (data_vec),
    .ctrl_go   (ctrl_go),
    .wr_req    (wr_req),
    .rd_req    (rd_req),
    .pg_addr   (pg_addr),
    .pg_we     (pg_we),
    .pg_mask   (pg_mask),
    .pg_wdata  (pg_wdata),
    .rd_word   (rd_word)
  );

  otp_page_store #(.PAGES(PAGES), .PAGE_AW(PAGE_AW)) u_store (
    .clk      (clk),
    .wr_en    (pg_we),
    .page_sel (pg_addr),
    .wr_mask  (pg_mask),
    .wr_page  (pg_wdata),
    .rd_page  (pg_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= (acc_ok && !bus_write) ? rd_word : '0;
      err_q   <= err_now;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;

endmodule

// File: rtl/otp_page_ctrl_chk.sv
module otp_page_ctrl_chk
  import otp_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic [1:0]    bus_size,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic          bus_err,
  input logic          acc_ok,
  input err_kind_e     err_kind,
  input logic          ctrl_go,
  input logic          pg_we,
  input logic [15:0]   ctrl_q,
  input logic [15:0]   ben_q,
  input logic [15:0]   stat_q,
  input logic [31:0]   timing_q,
  input logic [127:0]  data_vec
);

  logic bad_size;
  assign bad_size = (bus_size == 2'd0) || (bus_size == 2'd3);

  AST_WIDTH_BEFORE_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bad_size |-> err_kind == ERR_WIDTH) else $error("width priority"); // R2

  AST_REFUSE_PULSES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !acc_ok |=> bus_err) else $error("missing error pulse"); // R12

  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_valid) && !$past(acc_ok)) else $error("spurious error"); // R12

  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_rdata == 32'h0) else $error("error with data"); // R3

  AST_REFUSE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !acc_ok |=> $stable(ctrl_q) && $stable(ben_q) && $stable(timing_q)
      && $stable(data_vec) && $stable(stat_q)) else $error("refused write changed state"); // R4

  AST_DONE_AFTER_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_go |=> stat_q[DONE_BIT]) else $error("done not set"); // R10

  AST_WR_BIT_STARTS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_go && bus_wdata[CTRL_WR_BIT] |-> pg_we) else $error("page write missing"); // R6

  AST_CTRL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~CTRL_KEEP) == 16'h0) else $error("unkept control bit"); // R5

endmodule

bind otp_page_ctrl otp_page_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_size  (bus_size),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err),
  .acc_ok    (acc_ok),
  .err_kind  (err_kind),
  .ctrl_go   (ctrl_go),
  .pg_we     (pg_we),
  .ctrl_q    (ctrl_q),
  .ben_q     (ben_q),
  .stat_q    (stat_q),
  .timing_q  (timing_q),
  .data_vec  (data_vec)
);

// File: tb/otp_page_ctrl_tb.sv
module otp_page_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  otp_page_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  // Bench-side model of the programmer-visible state.
  logic [15:0]  m_ctrl, m_ben, m_stat;
  logic [31:0]  m_time;
  logic [31:0]  m_data [4];
  logic [127:0] m_page [512];

  // Index of a mapped register by offset, -1 if unmapped.
  function automatic int reg_index(input logic [7:0] a);
    case (a)
      8'h00: return 0;  8'h04: return 1;  8'h08: return 2;  8'h0C: return 3;
      8'h80: return 4;  8'h84: return 5;  8'h88: return 6;  8'h8C: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic logic accepted(input logic [7:0] a, input logic [1:0] s);
    int k;
    k = reg_index(a);
    if (k < 0) return 1'b0;
    return (k < 3) ? (s == 2'd1) : (s == 2'd2);
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (reg_index(a))
      0: return {16'h0, m_ctrl};
      1: return {16'h0, m_ben};
      2: return {16'h0, m_stat};
      3: return m_time;
      4: return m_data[0];
      5: return m_data[1];
      6: return m_data[2];
      7: return m_data[3];
      default: return 32'h0;
    endcase
  endfunction

  // Byte i of the 128-bit image sits in word i/4, lane i%4.
  function automatic logic [127:0] words_to_page();
    logic [127:0] p;
    for (int i = 0; i < 16; i++) p[i*8 +: 8] = m_data[i/4][(i%4)*8 +: 8];
    return p;
  endfunction

  function automatic logic [127:0] masked(input logic [127:0] keep, input logic [127:0] take,
                                          input logic [15:0] en);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) r[i*8 +: 8] = en[i] ? take[i*8 +: 8] : keep[i*8 +: 8];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic wr, input logic [7:0] a, input logic [1:0] s,
                        input logic [31:0] wd, output logic [31:0] rd, output logic er);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = s; bus_wdata = wd;
    @(negedge clk);
    rd = bus_rdata; er = bus_err;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  // Accepted write, updating the model.
  task automatic wr_reg(input logic [7:0] a, input logic [31:0] wd);
    logic [31:0] rd; logic er; int k; logic [127:0] img;
    k = reg_index(a);
    bus_op(1'b1, a, (k < 3) ? 2'd1 : 2'd2, wd, rd, er);
    check("R12 accepted write raises no error", {31'h0, er}, 32'h0);
    case (k)
      0: begin
        m_ctrl = wd[15:0] & 16'h39FF;
        if (wd[11]) m_page[wd[8:0]] = masked(m_page[wd[8:0]], words_to_page(), m_ben);
        if (wd[12]) begin
          img = masked(words_to_page(), m_page[wd[8:0]], m_ben);
          for (int w = 0; w < 4; w++) m_data[w] = img[w*32 +: 32];
        end
        m_stat[0] = 1'b1;
      end
      1: m_ben  = wd[15:0];
      2: m_stat = m_stat & ~wd[15:0];
      3: m_time = wd;
      default: m_data[k-4] = wd;
    endcase
  endtask

  task automatic rd_check(input string req, input logic [7:0] a);
    logic [31:0] rd; logic er;
    bus_op(1'b0, a, (reg_index(a) < 3) ? 2'd1 : 2'd2, 32'h0, rd, er);
    check(req, rd, model_read(a));
    check(req, {31'h0, er}, 32'h0);
  endtask

  task automatic read_all(input string req);
    logic [7:0] offs [8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h80, 8'h84, 8'h88, 8'h8C};
    for (int i = 0; i < 8; i++) rd_check(req, offs[i]);
  endtask

  task automatic load_data(input logic [31:0] seed);
    for (int w = 0; w < 4; w++) wr_reg(8'h80 + 8'(w*4), seed ^ (32'h1111_1111 * (w + 1)));
  endtask

  task automatic show_page(input string req, input logic [8:0] p);
    wr_reg(8'h04, 32'hFFFF);
    load_data(32'hDEAD_0000);
    wr_reg(8'h00, {19'h0, 1'b1, 3'b000, p});
    for (int w = 0; w < 4; w++) rd_check(req, 8'h80 + 8'(w*4));
  endtask

  initial begin
    logic [31:0] rd; logic er;
    logic [15:0] pats [5] = '{16'hFFFF, 16'h0000, 16'h00FF, 16'hA5C3, 16'h8001};
    logic [8:0]  pages [5] = '{9'h000, 9'h001, 9'h0AA, 9'h155, 9'h1FF};

    m_ctrl = 16'h0; m_ben = 16'hFFFF; m_stat = 16'h0; m_time = 32'h0000_1485;
    for (int w = 0; w < 4; w++) m_data[w] = 32'h0;

    repeat (3) @(negedge clk);
    check("R1 error low in reset", {31'h0, bus_err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 error low after reset", {31'h0, bus_err}, 32'h0);
    read_all("R1 reset value");

    // R2/R3: every offset against every size code, reads only.
    for (int a = 0; a < 256; a++) begin
      for (int s = 0; s < 4; s++) begin
        bus_op(1'b0, 8'(a), 2'(s), 32'h0, rd, er);
        check("R2 R3 error by offset and size", {31'h0, er}, {31'h0, !accepted(8'(a), 2'(s))});
        check("R3 R12 read data", rd, accepted(8'(a), 2'(s)) ? model_read(8'(a)) : 32'h0);
      end
    end

    // R4: wrong-width writes of all ones to every register change nothing.
    for (int k = 0; k < 8; k++) begin
      for (int s = 0; s < 4; s++) begin
        logic [7:0] a;
        a = (k < 4) ? 8'(k*4) : 8'(8'h80 + (k-4)*4);
        if (!accepted(a, 2'(s))) begin
          bus_op(1'b1, a, 2'(s), 32'hFFFF_FFFF, rd, er);
          check("R4 refused write flags error", {31'h0, er}, 32'h1);
        end
      end
    end
    read_all("R4 state after refused writes");

    // R11: full-width register writes.
    wr_reg(8'h04, 32'h0000_1234);
    wr_reg(8'h0C, 32'hCAFE_F00D);
    wr_reg(8'h80, 32'h0123_4567); wr_reg(8'h8C, 32'h89AB_CDEF);
    read_all("R11 register write");

    // R5: control mask; byte-enable 0 keeps page and data untouched.
    wr_reg(8'h04, 32'h0);
    wr_reg(8'h00, 32'h0000_FFFF);
    read_all("R5 control stored under mask");

    // R10: done set, write-0 keeps, write-1 clears.
    wr_reg(8'h08, 32'h0000_0000);
    rd_check("R10 write 0 keeps done", 8'h08);
    check("R10 done set by control write", {16'h0, m_stat}, 32'h1);
    wr_reg(8'h08, 32'h0000_0001);
    rd_check("R10 write 1 clears done", 8'h08);
    bus_op(1'b1, 8'h00, 2'd2, 32'h0000_0800, rd, er);
    rd_check("R4 R10 refused control write sets no done", 8'h08);

    // Initialise the chosen pages fully.
    wr_reg(8'h04, 32'hFFFF);
    for (int p = 0; p < 5; p++) begin
      load_data(32'h5A00_0000 + 32'(p));
      wr_reg(8'h00, {20'h0, 1'b1, 2'b00, pages[p]});
    end

    // R6/R8: masked page writes, read back with full enables.
    for (int p = 0; p < 5; p++) begin
      for (int q = 0; q < 5; q++) begin
        wr_reg(8'h04, 32'(pats[q]));
        load_data(32'h7000_0000 ^ 32'(p*16 + q));
        wr_reg(8'h00, {20'h0, 1'b1, 2'b00, pages[p]});
        show_page("R6 R8 masked page write", pages[p]);
      end
    end

    // R7: masked page reads into preset data words.
    for (int q = 0; q < 5; q++) begin
      wr_reg(8'h04, 32'hFFFF);
      load_data(32'h3C3C_0000 + 32'(q));
      wr_reg(8'h04, 32'(pats[q]));
      wr_reg(8'h00, {19'h0, 1'b1, 3'b000, pages[q]});
      for (int w = 0; w < 4; w++) rd_check("R7 masked page read", 8'h80 + 8'(w*4));
    end

    // R8: single byte lane checks.
    for (int i = 0; i < 16; i += 5) begin
      wr_reg(8'h04, 32'hFFFF);
      for (int w = 0; w < 4; w++) wr_reg(8'h80 + 8'(w*4), 32'h0);
      wr_reg(8'h00, {20'h0, 1'b1, 2'b00, 9'h077});
      wr_reg(8'h04, 32'(16'h1 << i));
      for (int w = 0; w < 4; w++) wr_reg(8'h80 + 8'(w*4), 32'hA1B2_C3D4);
      wr_reg(8'h00, {20'h0, 1'b1, 2'b00, 9'h077});
      show_page("R8 byte lane", 9'h077);
      check("R8 lane word", m_data[i/4], 32'hA1B2_C3D4 & (32'hFF << ((i%4)*8)));
    end

    // R9: both requests in one write.
    for (int q = 2; q < 5; q++) begin
      wr_reg(8'h04, 32'(pats[q]));
      load_data(32'h0F0F_0000 + 32'(q));
      wr_reg(8'h00, {19'h0, 2'b11, 2'b00, pages[q]});
      for (int w = 0; w < 4; w++) rd_check("R9 data kept after write then read", 8'h80 + 8'(w*4));
      show_page("R9 page after write then read", pages[q]);
    end

    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

endmodule